// File: doc/BRIEF.md
# Masked Interrupt Status Register

This block gathers interrupt events into one status word and raises a single interrupt line toward a host. Each of the lower 31 status bits is set by a one-cycle pulse on its own event input and stays set until the host clears it. A 32-bit mask word selects which pending bits count toward the summary. The summary is the top status bit. The interrupt pin is that summary gated by the top mask bit, so the host can silence the line without losing the pending state.

The host reaches the block through a plain register port: a byte address, a write strobe, write data, and read data that is decoded combinationally from the address. In normal operation the host clears status bits by writing ones, and the summary is recomputed by the block. A mode bit in a separate diagnostic register turns the whole status word, summary included, into ordinary storage. Test software uses this to force any status pattern.

Top module: `irq_status_ctrl`

## Requirements
- R1: While and after reset the status word reads 0x8000_0000 (summary set, all event bits clear), the mask word reads 0, the diagnostic mode bit is 0 and irq_o is 0.
- R2: The mask word at byte offset 0x10 is read/write over all 32 bits; a write takes effect at the next clock edge.
- R3: A 1 on evt_i[k] (k = 0..30) sets status bit k at the next clock edge, and the bit stays set until the host clears it.
- R4: In normal mode (diagnostic bit 0), a write to the status word at offset 0x0C clears each bit k in 0..30 whose write data bit is 1, leaves bits written with 0 unchanged, and has no effect on the summary bit 31.
- R5: When an event pulse and a host clear or write target the same status bit in the same cycle, the bit ends up set.
- R6: In normal mode the summary bit 31 is loaded at every clock edge with the OR over k = 0..30 of status bit k AND mask bit k, as held before that edge, so it follows the pending state one clock later and reads 1 again after a clear if a qualifying bit is still pending.
- R7: In diagnostic mode a write to offset 0x0C loads status bits 30..0 with the write data (events still set bits per R5) and loads the summary bit 31 from write data bit 31; without a write, the summary bit holds its value.
- R8: irq_o is 1 exactly when status bit 31 and mask bit 31 are both 1.
- R9: The diagnostic register at offset 0x20 holds the mode bit in bit 0, writable and readable; its bits 31..1 read as 0.
- R10: Reads of any address other than 0x0C, 0x10 and 0x20 return 0, and writes to such addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address of the register access |
| we_i | input | 1 | Write strobe, one write per cycle in which it is high |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| evt_i | input | 31 | Event pulses, bit k sets status bit k |
| irq_o | output | 1 | Interrupt line |

## Verification
The assertions assume that address, write strobe, write data and event inputs are known and steady around each rising edge. They also assume that a write strobe always comes with a meaningful address, since every write is decoded against the three offsets. The stimulus changes these inputs only one nanosecond after a rising edge and holds them for a full cycle. Event pulses are allowed to cover several bits at once and to collide with clears and diagnostic writes. This lets the precedence rule and the one-cycle lag of the summary be observed under overlap and not only in isolation.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam int unsigned OFS_STAT = 32'h0C;
  localparam int unsigned OFS_MASK = 32'h10;
  localparam int unsigned OFS_DIAG = 32'h20;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_MASK = 2'd2,
    SEL_DIAG = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);

  always_comb begin
    if (addr_i == ADDR_W'(OFS_STAT))      sel_o = SEL_STAT;
    else if (addr_i == ADDR_W'(OFS_MASK)) sel_o = SEL_MASK;
    else if (addr_i == ADDR_W'(OFS_DIAG)) sel_o = SEL_DIAG;
    else                                  sel_o = SEL_NONE;
  end

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_mask_i,
  input  logic              wr_diag_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mask_o,
  output logic              diag_o
);

  logic [DATA_W-1:0] mask_q;
  logic              diag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (wr_mask_i) begin
      mask_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      diag_q <= 1'b0;
    end else if (wr_diag_i) begin
      diag_q <= wdata_i[0];
    end
  end

  assign mask_o = mask_q;
  assign diag_o = diag_q;

  p_mask_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask_i |=> (mask_q == $past(wdata_i)));

  p_mask_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mask_i |=> $stable(mask_q));

  p_diag_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_diag_i |=> $stable(diag_q));

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned DATA_W  = 32,
  parameter logic        SUM_RST = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              diag_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-2:0] evt_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] stat_o
);

  localparam int unsigned LOW_W = DATA_W - 1;
  localparam int unsigned SUM_B = DATA_W - 1;

  logic [LOW_W-1:0] low_q;
  logic             sum_q;

  // event beats clear/write on the same bit
  for (genvar b = 0; b < LOW_W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        low_q[b] <= 1'b0;
      end else if (evt_i[b]) begin
        low_q[b] <= 1'b1;
      end else if (wr_i) begin
        low_q[b] <= diag_i ? wdata_i[b] : (low_q[b] & ~wdata_i[b]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= SUM_RST;
    end else if (diag_i) begin
      if (wr_i) sum_q <= wdata_i[SUM_B];
    end else begin
      sum_q <= |(low_q & mask_i[LOW_W-1:0]);
    end
  end

  assign stat_o = {sum_q, low_q};

  p_evt_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((stat_o[LOW_W-1:0] & $past(evt_i)) == $past(evt_i)));

  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !diag_i) |=>
      ((stat_o[LOW_W-1:0] & $past(wdata_i[LOW_W-1:0] & ~evt_i)) == '0));

  p_no_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ((stat_o[LOW_W-1:0] & $past(stat_o[LOW_W-1:0]))
               == $past(stat_o[LOW_W-1:0])));

  p_diag_wr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && diag_i) |=>
      (stat_o == $past({wdata_i[SUM_B], wdata_i[LOW_W-1:0] | evt_i})));

  p_sum_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (diag_i && !wr_i) |=> $stable(stat_o[SUM_B]));

  p_sum_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!diag_i && ((stat_o[LOW_W-1:0] & mask_i[LOW_W-1:0]) == '0)) |=> !stat_o[SUM_B]);

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-2:0] evt_i,
  output logic              irq_o
);

  localparam int unsigned SUM_B = DATA_W - 1;

  reg_sel_e          sel;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] stat;
  logic              diag;

  irq_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  irq_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_mask_i (we_i && (sel == SEL_MASK)),
    .wr_diag_i (we_i && (sel == SEL_DIAG)),
    .wdata_i   (wdata_i),
    .mask_o    (mask),
    .diag_o    (diag)
  );

  irq_status_reg #(.DATA_W(DATA_W), .SUM_RST(1'b1)) u_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .diag_i  (diag),
    .wr_i    (we_i && (sel == SEL_STAT)),
    .wdata_i (wdata_i),
    .evt_i   (evt_i),
    .mask_i  (mask),
    .stat_o  (stat)
  );

  always_comb begin
    unique case (sel)
      SEL_STAT: rdata_o = stat;
      SEL_MASK: rdata_o = mask;
      SEL_DIAG: rdata_o = {{(DATA_W-1){1'b0}}, diag};
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = stat[SUM_B] & mask[SUM_B];

  p_irq_masked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask[SUM_B] |-> !irq_o);

  p_irq_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat[SUM_B] |-> !irq_o);

  p_other_rd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_NONE) |-> (rdata_o == '0));

  p_diag_rd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_DIAG) |-> (rdata_o[DATA_W-1:1] == '0));

endmodule

// File: tb/irq_status_ctrl_tb.sv
module irq_status_ctrl_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = 8'h0C;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [30:0] evt_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R1";

  // reference state
  logic [31:0] m_stat;
  logic [31:0] m_mask;
  logic        m_diag;

  always #2 clk_i = ~clk_i;

  irq_status_ctrl dut_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .evt_i   (evt_i),
    .irq_o   (irq_o)
  );

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_stat <= 32'h8000_0000;
      m_mask <= 32'h0;
      m_diag <= 1'b0;
    end else begin
      logic [31:0] ns;
      logic        pend;
      ns = m_stat;
      pend = 1'b0;
      for (int k = 0; k < 31; k++) if (m_stat[k] && m_mask[k]) pend = 1'b1;
      if (we_i && addr_i == 8'h0C) begin
        for (int k = 0; k < 31; k++) begin
          if (m_diag) ns[k] = wdata_i[k];
          else if (wdata_i[k]) ns[k] = 1'b0;
        end
        if (m_diag) ns[31] = wdata_i[31];
      end
      if (!m_diag) ns[31] = pend;
      for (int k = 0; k < 31; k++) if (evt_i[k]) ns[k] = 1'b1;
      m_stat <= ns;
      if (we_i && addr_i == 8'h10) m_mask <= wdata_i;
      if (we_i && addr_i == 8'h20) m_diag <= wdata_i[0];
    end
  end

  function automatic logic [31:0] exp_read(logic [7:0] a);
    case (a)
      8'h0C:   return m_stat;
      8'h10:   return m_mask;
      8'h20:   return {31'b0, m_diag};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h @%0t", t, addr_i, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    cycles++;
    check(tag, rdata_o, exp_read(addr_i));
    check("R8", {31'b0, irq_o}, {31'b0, m_stat[31] & m_mask[31]});
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic bus(logic [7:0] a, logic w, logic [31:0] d, logic [30:0] e);
    @(posedge clk_i);
    #1;
    addr_i = a; we_i = w; wdata_i = d; evt_i = e;
  endtask

  task automatic rd(logic [7:0] a);
    bus(a, 1'b0, 32'h0, 31'h0);
  endtask

  initial begin
    logic [31:0] lfsr;
    tag = "R1";
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    rd(8'h10);
    rd(8'h20);
    rd(8'h0C);

    tag = "R2";
    bus(8'h10, 1'b1, 32'hA5A5_5A5A, 31'h0);
    rd(8'h10);
    bus(8'h10, 1'b1, 32'h5A5A_A5A5, 31'h0);
    rd(8'h10);
    bus(8'h10, 1'b1, 32'hA5A5_5A5A, 31'h0);

    tag = "R3";
    bus(8'h0C, 1'b0, 32'h0, 31'h0000_0011);
    rd(8'h0C);
    bus(8'h0C, 1'b0, 32'h0, 31'h4000_0000);
    rd(8'h0C);

    tag = "R6";
    rd(8'h0C);
    rd(8'h0C);

    tag = "R4";
    bus(8'h0C, 1'b1, 32'h8000_0010, 31'h0);
    rd(8'h0C);
    rd(8'h0C);
    bus(8'h0C, 1'b1, 32'h0000_0000, 31'h0);
    rd(8'h0C);

    tag = "R6";
    bus(8'h0C, 1'b0, 32'h0, 31'h0000_0002);
    bus(8'h0C, 1'b1, 32'h0000_0002, 31'h0000_0008);
    rd(8'h0C);
    rd(8'h0C);

    tag = "R5";
    bus(8'h0C, 1'b1, 32'h7FFF_FFFF, 31'h0000_0001);
    rd(8'h0C);
    rd(8'h0C);

    tag = "R8";
    bus(8'h10, 1'b1, 32'h0000_000F, 31'h0);
    bus(8'h0C, 1'b0, 32'h0, 31'h0000_0004);
    rd(8'h0C);
    bus(8'h10, 1'b1, 32'h8000_000F, 31'h0);
    rd(8'h0C);
    rd(8'h0C);

    tag = "R9";
    bus(8'h20, 1'b1, 32'hFFFF_FFFF, 31'h0);
    rd(8'h20);
    bus(8'h20, 1'b1, 32'hFFFF_FFFE, 31'h0);
    rd(8'h20);
    bus(8'h20, 1'b1, 32'h0000_0001, 31'h0);

    tag = "R7";
    bus(8'h0C, 1'b1, 32'h1234_5678, 31'h0000_0001);
    rd(8'h0C);
    bus(8'h0C, 1'b1, 32'h8000_0000, 31'h0);
    rd(8'h0C);
    bus(8'h10, 1'b1, 32'h0000_0000, 31'h0);
    rd(8'h0C);
    rd(8'h0C);
    bus(8'h0C, 1'b1, 32'h0000_0000, 31'h0);
    rd(8'h0C);
    bus(8'h20, 1'b1, 32'h0, 31'h0);
    rd(8'h0C);

    tag = "R10";
    bus(8'h14, 1'b1, 32'hFFFF_FFFF, 31'h0);
    rd(8'h14);
    bus(8'h0D, 1'b1, 32'hFFFF_FFFF, 31'h0);
    bus(8'h00, 1'b1, 32'hFFFF_FFFF, 31'h0);
    rd(8'h10);
    rd(8'h20);
    rd(8'h0C);
    rd(8'hFF);

    tag = "R6";
    lfsr = 32'hACE1_2345;
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[2:0])
        3'd0, 3'd1, 3'd2: a = 8'h0C;
        3'd3:             a = 8'h10;
        3'd4:             a = 8'h20;
        default:          a = lfsr[10:3];
      endcase
      bus(a, lfsr[12] & lfsr[13], {lfsr[15:0], lfsr[31:16]},
          lfsr[20] ? {lfsr[5:0], lfsr[30:6]} & 31'h0101_0101 : 31'h0);
    end

    rd(8'h0C);
    rd(8'h0C);
    @(posedge clk_i);
    @(posedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule